// File: doc/BRIEF.md
# Two-Slot VLIW Datapath with Distributed Register Files

This block is a compact two-issue VLIW datapath. The first issue slot drives an arithmetic/logic unit and the second drives a signed multiply-accumulate unit. Each unit reads its two operands from a private pair of four-entry register files. Two result busses carry the unit outputs back to all four files. Bus 0 carries the registered ALU result and bus 1 carries the MAC accumulator.

A 20-bit instruction word is applied every cycle, and its raw fields control the whole datapath with no decoding stage. The fields select the unit operations, the operand read addresses, the write address, the write enable and the bus that feeds each slot's register-file input multiplexer. Both slots act in the same cycle. A data input port enters values into the datapath through one ALU opcode. The bus values and the unit flags are outputs, so the datapath can be observed.

Top module: `vliw2_datapath`

## Requirements
- R1: The ALU slot uses `instr[19:10]` and the MAC slot uses `instr[9:0]`. Each slot is laid out as [9:8] opcode, [7:6] read address of its first file, [5:4] read address of its second file, [3:2] write address, [1] write enable and [0] bus select (0 = ALU bus, 1 = MAC bus). The ALU slot's first file is RF1 and its second is RF2. The MAC slot's files are RF3 and RF4.
- R2: The ALU opcodes are 00 = a+b, 01 = a−b, 10 = a AND b and 11 = pass `data_in`. Here a is the value read from RF1 and b is the value read from RF2. The result wraps to DATA_W bits and appears on `bus_alu` after the next clock edge.
- R3: `alu_zero` is 1 exactly when `bus_alu` is zero. `alu_neg` equals the most significant bit of `bus_alu`.
- R4: MAC opcode 01 sets acc = acc + a·b, where a and b are the signed values read from RF3 and RF4. The result wraps to DATA_W bits, and `bus_mac` shows the accumulator after the next clock edge.
- R5: MAC opcode 00 holds the accumulator and its flag. Opcode 10 clears both. Opcode 11 loads acc = a·b (wrapped).
- R6: On opcodes 01 and 11, `mac_ovf` becomes 1 when the exact signed result does not fit in DATA_W signed bits, and 0 otherwise.
- R7: When a slot's write enable is 1, both of its register files store the selected bus value at the write address. The value stored is the one on the bus during that cycle. When the write enable is 0, neither file of that slot changes.
- R8: If a cycle reads the entry that the same cycle writes, the read returns the value held before the write.
- R9: The two slots act in the same cycle and independently of each other. Each slot may select either bus.
- R10: A synchronous active-low reset clears all register-file entries, both busses and `mac_ovf`, and sets `alu_zero` to 1 and `alu_neg` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 20 | Instruction word for this cycle |
| data_in | input | DATA_W | External value passed by ALU opcode 11 |
| bus_alu | output | DATA_W | Bus 0: registered ALU result |
| bus_mac | output | DATA_W | Bus 1: MAC accumulator |
| alu_zero | output | 1 | ALU result is zero |
| alu_neg | output | 1 | ALU result is negative |
| mac_ovf | output | 1 | Signed overflow of the last MAC update |

## Verification
Every cycle, the assertions check that the ALU flags agree with `bus_alu`. They also check the pass, add, clear and hold opcodes against the operands and ports of the previous cycle, and check the values left after reset. Register-file behaviour can only be seen through later reads, so only the bench scenarios can show it. This covers the shared write address, the choice of bus, read-before-write and the independence of the two slots. The bench replays long random instruction streams and directed overflow and hazard sequences against a cycle model.

// File: rtl/vliw2_pkg.sv
// Shared types for the two-slot VLIW datapath.
// Assumes the fixed 20-bit instruction split into two 10-bit slots.
package vliw2_pkg;

    localparam int SLOT_W   = 10;
    localparam int INSTR_W  = 2 * SLOT_W;
    localparam int RF_DEPTH = 4;
    localparam int RF_AW    = $clog2(RF_DEPTH);

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_SUB  = 2'b01,
        ALU_AND  = 2'b10,
        ALU_PASS = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        MAC_HOLD = 2'b00,
        MAC_ACC  = 2'b01,
        MAC_CLR  = 2'b10,
        MAC_LOAD = 2'b11
    } mac_op_e;

    typedef struct packed {
        logic [1:0]       op;
        logic [RF_AW-1:0] ra_first;
        logic [RF_AW-1:0] ra_second;
        logic [RF_AW-1:0] wa;
        logic             we;
        logic             bus_sel;
    } slot_t;

endpackage

// File: rtl/vliw2_regfile.sv
// Small register file with one read port and one write port.
// Reads are combinational and see the contents from before any write
// in the same cycle. Writes take effect at the clock edge.
module vliw2_regfile #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage update: clear on reset, otherwise write one entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read port: asynchronous lookup of the current contents.
    always_comb begin
        rd_data = mem[rd_addr];
    end

endmodule

// File: rtl/vliw2_alu.sv
// ALU issue-slot unit: add, subtract, bitwise AND, or pass of an
// external value. The result and the zero/negative flags are registered.
// Assumes the operands are stable during the cycle.
module vliw2_alu #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] ext_val,
    output logic [DATA_W-1:0] result_q,
    output logic              zero_q,
    output logic              neg_q
);

    import vliw2_pkg::*;

    logic [DATA_W-1:0] result_d;

    // Operation select: compute the next result from the opcode.
    always_comb begin
        unique case (alu_op_e'(op))
            ALU_ADD:  result_d = opnd_a + opnd_b;
            ALU_SUB:  result_d = opnd_a - opnd_b;
            ALU_AND:  result_d = opnd_a & opnd_b;
            ALU_PASS: result_d = ext_val;
            default:  result_d = '0;
        endcase
    end

    // Result register: capture the result and flags every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            zero_q   <= 1'b1;
            neg_q    <= 1'b0;
        end else begin
            result_q <= result_d;
            zero_q   <= (result_d == '0);
            neg_q    <= result_d[DATA_W-1];
        end
    end

endmodule

// File: rtl/vliw2_mac.sv
// Signed multiply-accumulate unit with a DATA_W accumulator.
// The accumulator wraps on overflow. A flag records whether the last
// accumulate or load left the signed range.
module vliw2_mac #(
    parameter int DATA_W = 16,
    localparam int PW    = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] acc_q,
    output logic              ovf_q
);

    import vliw2_pkg::*;

    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;
    logic [PW-1:0] prod;
    logic [PW:0]   acc_ext;
    logic [PW:0]   exact;
    logic [PW-DATA_W+1:0] top_bits;
    logic          out_of_range;

    // Product: sign-extend both operands so the product is exact in PW bits.
    always_comb begin
        a_ext = {{DATA_W{opnd_a[DATA_W-1]}}, opnd_a};
        b_ext = {{DATA_W{opnd_b[DATA_W-1]}}, opnd_b};
        prod  = a_ext * b_ext;
    end

    // Exact result: either acc + product or product alone, one bit wider.
    always_comb begin
        acc_ext = {{(PW + 1 - DATA_W){acc_q[DATA_W-1]}}, acc_q};
        if (mac_op_e'(op) == MAC_LOAD) begin
            exact = {prod[PW-1], prod};
        end else begin
            exact = acc_ext + {prod[PW-1], prod};
        end
        top_bits     = exact[PW:DATA_W-1];
        out_of_range = !((&top_bits) || !(|top_bits));
    end

    // Accumulator register: hold, accumulate, clear or load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            unique case (mac_op_e'(op))
                MAC_HOLD: begin
                    acc_q <= acc_q;
                    ovf_q <= ovf_q;
                end
                MAC_CLR: begin
                    acc_q <= '0;
                    ovf_q <= 1'b0;
                end
                default: begin
                    acc_q <= exact[DATA_W-1:0];
                    ovf_q <= out_of_range;
                end
            endcase
        end
    end

endmodule

// File: rtl/vliw2_datapath.sv
// Two-slot VLIW datapath top. Slot 0 (instr[19:10]) drives the ALU and
// slot 1 (instr[9:0]) drives the MAC. Each slot owns two register files
// whose inputs are fed by a bus multiplexer. Both files of a slot share
// the slot's write address and write enable. Bus 0 is the registered ALU
// result and bus 1 is the accumulator. Assumes one instruction per cycle.
module vliw2_datapath #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [19:0]       instr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] bus_alu,
    output logic [DATA_W-1:0] bus_mac,
    output logic              alu_zero,
    output logic              alu_neg,
    output logic              mac_ovf
);

    import vliw2_pkg::*;

    localparam int NUM_SLOTS = 2;

    slot_t             slot_f  [NUM_SLOTS];
    logic [DATA_W-1:0] bus_val [NUM_SLOTS];
    logic [DATA_W-1:0] opnd_a  [NUM_SLOTS];
    logic [DATA_W-1:0] opnd_b  [NUM_SLOTS];
    logic [DATA_W-1:0] alu_a;
    logic [DATA_W-1:0] alu_b;
    logic [DATA_W-1:0] mac_a;
    logic [DATA_W-1:0] mac_b;

    // Field split: the upper slot is the ALU slot, the lower slot the MAC slot.
    always_comb begin
        slot_f[0] = slot_t'(instr[INSTR_W-1:SLOT_W]);
        slot_f[1] = slot_t'(instr[SLOT_W-1:0]);
    end

    // Bus sources: index 0 is the ALU result, index 1 the accumulator.
    always_comb begin
        bus_val[0] = bus_alu;
        bus_val[1] = bus_mac;
    end

    // One pair of register files per slot, each fed by its slot's bus mux.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [DATA_W-1:0] wr_mux;

        // Input multiplexer: choose the bus named by the slot's select bit.
        always_comb begin
            wr_mux = bus_val[slot_f[s].bus_sel];
        end

        vliw2_regfile #(.DATA_W(DATA_W), .DEPTH(RF_DEPTH)) u_rf_first (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (slot_f[s].we),
            .wr_addr (slot_f[s].wa),
            .wr_data (wr_mux),
            .rd_addr (slot_f[s].ra_first),
            .rd_data (opnd_a[s])
        );

        vliw2_regfile #(.DATA_W(DATA_W), .DEPTH(RF_DEPTH)) u_rf_second (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (slot_f[s].we),
            .wr_addr (slot_f[s].wa),
            .wr_data (wr_mux),
            .rd_addr (slot_f[s].ra_second),
            .rd_data (opnd_b[s])
        );
    end

    // Operand naming: flatten the per-slot operands for the units.
    always_comb begin
        alu_a = opnd_a[0];
        alu_b = opnd_b[0];
        mac_a = opnd_a[1];
        mac_b = opnd_b[1];
    end

    vliw2_alu #(.DATA_W(DATA_W)) u_alu (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (slot_f[0].op),
        .opnd_a   (alu_a),
        .opnd_b   (alu_b),
        .ext_val  (data_in),
        .result_q (bus_alu),
        .zero_q   (alu_zero),
        .neg_q    (alu_neg)
    );

    vliw2_mac #(.DATA_W(DATA_W)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (slot_f[1].op),
        .opnd_a (mac_a),
        .opnd_b (mac_b),
        .acc_q  (bus_mac),
        .ovf_q  (mac_ovf)
    );

endmodule

// File: rtl/vliw2_datapath_chk.sv
// Property checker for the two-slot VLIW datapath, attached by bind.
// It sees the top ports plus the operands that the register files deliver.
module vliw2_datapath_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [19:0]       instr,
    input logic [DATA_W-1:0] data_in,
    input logic [DATA_W-1:0] bus_alu,
    input logic [DATA_W-1:0] bus_mac,
    input logic              alu_zero,
    input logic              alu_neg,
    input logic              mac_ovf,
    input logic [DATA_W-1:0] alu_a,
    input logic [DATA_W-1:0] alu_b
);

    logic [1:0] alu_op;
    logic [1:0] mac_op;

    // Opcode taps: the opcode fields of each slot.
    always_comb begin
        alu_op = instr[19:18];
        mac_op = instr[9:8];
    end

    // R10: reset leaves the busses, overflow flag and ALU flags in their reset values.
    a_r10_reset_state: assert property (@(posedge clk)
        !rst_n |=> (bus_alu == '0) && (bus_mac == '0) && alu_zero && !alu_neg && !mac_ovf);

    // R3: the zero flag matches the ALU bus.
    a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        alu_zero == (bus_alu == '0));

    // R3: the negative flag matches the sign bit of the ALU bus.
    a_r3_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
        alu_neg == bus_alu[DATA_W-1]);

    // R2: the pass opcode places the external value on the ALU bus.
    a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 2'b11) |=> (bus_alu == $past(data_in)));

    // R2: the add opcode places the wrapped sum of the register-file operands on the bus.
    a_r2_add: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == 2'b00) |=> (bus_alu == DATA_W'($past(alu_a) + $past(alu_b))));

    // R5: clear zeroes both the accumulator and its flag.
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_op == 2'b10) |=> ((bus_mac == '0) && !mac_ovf));

    // R5: hold keeps both the accumulator and its flag.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_op == 2'b00) |=> ($stable(bus_mac) && $stable(mac_ovf)));

endmodule

bind vliw2_datapath vliw2_datapath_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr    (instr),
    .data_in  (data_in),
    .bus_alu  (bus_alu),
    .bus_mac  (bus_mac),
    .alu_zero (alu_zero),
    .alu_neg  (alu_neg),
    .mac_ovf  (mac_ovf),
    .alu_a    (alu_a),
    .alu_b    (alu_b)
);

// File: tb/vliw2_datapath_bench.sv
// Self-checking bench: a cycle model of the datapath predicts every output.
// The stimulus is random instruction words with a fixed seed, plus directed
// hazard and overflow sequences.
module vliw2_datapath_bench;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [19:0]   instr;
    logic [DW-1:0] data_in;
    logic [DW-1:0] bus_alu;
    logic [DW-1:0] bus_mac;
    logic          alu_zero;
    logic          alu_neg;
    logic          mac_ovf;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    // Model state: m_rf[0..3] stand for RF1..RF4.
    logic [DW-1:0] m_rf [4][4];
    logic [DW-1:0] m_alu;
    logic [DW-1:0] m_acc;
    logic          m_zero;
    logic          m_neg;
    logic          m_ovf;

    vliw2_datapath #(.DATA_W(DW)) u_vliw2_datapath (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr    (instr),
        .data_in  (data_in),
        .bus_alu  (bus_alu),
        .bus_mac  (bus_mac),
        .alu_zero (alu_zero),
        .alu_neg  (alu_neg),
        .mac_ovf  (mac_ovf)
    );

    // Clock: 8 ns period.
    always #4ns clk = ~clk;

    // Slot builder: opcode, first read, second read, write address, enable, bus.
    function automatic logic [9:0] slot(input logic [1:0] op, input logic [1:0] ra,
                                        input logic [1:0] rb, input logic [1:0] wa,
                                        input logic we, input logic sel);
        return {op, ra, rb, wa, we, sel};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every output with the model; tag names the scenario.
    task automatic check_all(input string tag);
        chk({"R2 ", tag}, "bus_alu", bus_alu, m_alu);
        chk({"R3 ", tag}, "alu_zero", DW'(alu_zero), DW'(m_zero));
        chk({"R3 ", tag}, "alu_neg", DW'(alu_neg), DW'(m_neg));
        chk({"R4 ", tag}, "bus_mac", bus_mac, m_acc);
        chk({"R6 ", tag}, "mac_ovf", DW'(mac_ovf), DW'(m_ovf));
    endtask

    task automatic model_reset();
        for (int f = 0; f < 4; f++)
            for (int e = 0; e < 4; e++)
                m_rf[f][e] = '0;
        m_alu = '0; m_acc = '0; m_zero = 1'b1; m_neg = 1'b0; m_ovf = 1'b0;
    endtask

    // One model cycle: reads see the old contents and writes take the old bus values.
    task automatic model_step(input logic [19:0] ins, input logic [DW-1:0] din);
        logic [9:0]    s0 = ins[19:10];
        logic [9:0]    s1 = ins[9:0];
        logic [DW-1:0] a  = m_rf[0][s0[7:6]];
        logic [DW-1:0] b  = m_rf[1][s0[5:4]];
        logic [DW-1:0] c  = m_rf[2][s1[7:6]];
        logic [DW-1:0] d  = m_rf[3][s1[5:4]];
        logic [DW-1:0] w0 = s0[0] ? m_acc : m_alu;
        logic [DW-1:0] w1 = s1[0] ? m_acc : m_alu;
        logic [DW-1:0] r;
        longint        ex;
        case (s0[9:8])
            2'b00:   r = a + b;
            2'b01:   r = a - b;
            2'b10:   r = a & b;
            default: r = din;
        endcase
        ex = longint'($signed(c)) * longint'($signed(d));
        if (s1[9:8] == 2'b01) ex = ex + longint'($signed(m_acc));
        if (s0[1]) begin m_rf[0][s0[3:2]] = w0; m_rf[1][s0[3:2]] = w0; end
        if (s1[1]) begin m_rf[2][s1[3:2]] = w1; m_rf[3][s1[3:2]] = w1; end
        m_alu = r; m_zero = (r == '0); m_neg = r[DW-1];
        case (s1[9:8])
            2'b00: ;
            2'b10: begin m_acc = '0; m_ovf = 1'b0; end
            default: begin
                m_acc = ex[DW-1:0];
                m_ovf = (ex > 64'sd32767) || (ex < -64'sd32768);
            end
        endcase
    endtask

    // Drive one instruction at a falling edge and check the result one cycle later.
    task automatic issue(input logic [19:0] ins, input logic [DW-1:0] din, input string tag);
        instr = ins; data_in = din;
        model_step(ins, din);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Watchdog: an overlong run counts as a failure.
    initial begin
        #(8ns * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; instr = '0; data_in = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R10 reset state");
        rst_n = 1'b1;

        // R2/R1: enter 5 through the pass opcode.
        issue({slot(2'b11, 0, 0, 0, 0, 0), slot(2'b00, 0, 0, 0, 0, 0)}, 16'd5, "R1 pass");
        // R8 R7 R9: write bus 0 into RF1/RF2[0] while adding those entries (old values 0),
        // and in the same cycle write bus 0 into RF3/RF4[1].
        issue({slot(2'b00, 0, 0, 0, 1, 0), slot(2'b00, 0, 0, 1, 1, 0)}, 16'd0, "R8 read-before-write");
        // R7: new contents are visible: 5+5; the MAC loads 5*5.
        issue({slot(2'b00, 0, 0, 0, 0, 0), slot(2'b11, 1, 1, 0, 0, 0)}, 16'd0, "R7 write visible");
        // R4: accumulate 25+25 and pass 0x7FFF.
        issue({slot(2'b11, 0, 0, 0, 0, 0), slot(2'b01, 1, 1, 0, 0, 0)}, 16'h7FFF, "R4 accumulate");
        // R7: the MAC slot takes 0x7FFF from bus 0 into entry 2; subtract 5-5 gives zero.
        issue({slot(2'b01, 0, 0, 0, 0, 0), slot(2'b00, 0, 0, 2, 1, 0)}, 16'd0, "R3 zero");
        // R6: load 0x7FFF squared overflows.
        issue({slot(2'b11, 0, 0, 0, 0, 0), slot(2'b11, 2, 2, 0, 0, 0)}, 16'h8000, "R6 overflow");
        // R5: hold keeps the wrapped accumulator and the flag; R3 negative from 0x8000.
        issue({slot(2'b10, 0, 0, 3, 1, 1), slot(2'b00, 0, 0, 0, 0, 0)}, 16'd0, "R5 hold");
        // R9: the ALU slot stored the accumulator from bus 1 into entry 3; AND reads it.
        issue({slot(2'b10, 3, 3, 0, 0, 0), slot(2'b10, 0, 0, 0, 0, 0)}, 16'd0, "R5 clear");
        // R6: accumulating small values after the clear leaves the flag low.
        issue({slot(2'b00, 0, 0, 0, 0, 0), slot(2'b01, 1, 1, 0, 0, 0)}, 16'd0, "R6 no overflow");

        // Random mix: all opcodes, addresses and bus selects.
        for (int i = 0; i < 4000; i++) begin
            issue(20'($urandom), 16'($urandom), "R9 random");
        end

        // R10: reset in mid-run clears everything again.
        rst_n = 1'b0; instr = '0;
        model_reset();
        @(negedge clk);
        check_all("R10 mid-run reset");
        rst_n = 1'b1;
        // R7: after reset every entry reads zero; the sum of two entries is zero.
        issue({slot(2'b00, 3, 2, 0, 0, 0), slot(2'b11, 3, 1, 0, 0, 0)}, 16'd0, "R10 files cleared");

        finished = 1'b1;
        report();
        $finish;
    end

endmodule